// File: doc/BRIEF.md
# Inset Window Compositor

This block draws a small inset window onto a main video raster. It keeps a column counter and a line counter, both driven by line and frame strobes from the main picture. For every output pixel it chooses one of five results: stored inset picture data, a border colour, a solid fill colour, black, or the neutral level used outside the window. The window's top-left corner comes from two 6-bit position codes. Each code splits the full display into 64 steps. A size select picks one of two interior sizes, and a coloured ring of fixed thickness surrounds the interior.

Inset pixel data come from an external field memory. The block raises a read request one clock before it samples each interior picture pixel. The sync guard turns the whole window off when its outer rectangle would reach into the horizontal or vertical sync region. Blanking turns the whole window black and wins over every other control. The outputs are 6-bit Y, U and V, where U and V are bipolar around mid-scale, plus a flag that is high wherever the window is drawn. Analogue conversion and colour encoding follow this block and are not part of it.

Top module: `pip_window_compositor`

## Requirements
- R1: While reset is high, and on the first cycle after it falls, the outputs read Y=0, U=32, V=32, with win_active=0 and rd_req=0. The counters restart at column 0, line 0.
- R2: A high line_strobe sets the next cycle to column 0. It also advances the line count, or sets it to 0 when frame_strobe is high at the same time. When no strobe arrives, the column count stops at the last column and the line count stops at the last line. The outer window starts at column x_code*LINE_PIX/64 and line y_code*FRAME_LINES/64 (integer division). It spans W+2*BORDER_W columns and H+2*BORDER_H lines, where W×H is LARGE_W×LARGE_H when size_large=1 and SMALL_W×SMALL_H when size_large=0. The pixel at counter position (h,v) reaches the outputs three cycles after the cycle in which the counters hold (h,v).
- R3: The ring is the outer BORDER_W columns on each side and the outer BORDER_H lines at top and bottom. In the ring the colour follows border_code: 000 gives black (0,32,32), 001 gives grey (44,32,32), 100 gives blue (7,60,27), 101 gives green (37,13,9), 110 gives red (19,21,60) and 111 gives white (63,32,32). The triples are Y,U,V.
- R4: border_code 010 or 011 makes the ring transparent. The ring pixels then carry the neutral level with win_active=0.
- R5: Every pixel that is not drawn carries Y=0, U=32, V=32 with win_active=0.
- R6: The window is not drawn at all if the outer start column is below SYNC_PIX, if the outer end passes LINE_PIX, if the start line is below SYNC_LINES, or if the outer end passes FRAME_LINES.
- R7: With pip_blank=1, every pixel of the window, ring included, is black (0,32,32) with win_active=1. This holds whatever the fill and border codes are, and no read is requested.
- R8: With pip_enable=0, nothing is drawn and no read is requested.
- R9: In the interior, fill_code 01 gives red, 10 gives green and 11 gives blue, using the R3 values. No read is requested then.
- R10: When fill_code=00 and the window is not blanked, each interior pixel raises rd_req in the cycle before the pix inputs are sampled. The sampled pix_y, pix_u and pix_v values appear unchanged on the outputs one cycle later, with win_active=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| line_strobe | input | 1 | Start of a main-picture line |
| frame_strobe | input | 1 | Start of a frame; acts only together with line_strobe |
| x_code | input | 6 | Horizontal start step |
| y_code | input | 6 | Vertical start step |
| size_large | input | 1 | 1 selects the large interior, 0 the small one |
| pip_enable | input | 1 | 1 allows the window to be drawn |
| pip_blank | input | 1 | 1 makes the whole window black |
| fill_code | input | 2 | Solid interior colour; 00 shows the picture |
| border_code | input | 3 | Ring colour or transparent ring |
| pix_y | input | 6 | Inset luma from memory |
| pix_u | input | 6 | Inset U from memory |
| pix_v | input | 6 | Inset V from memory |
| rd_req | output | 1 | Memory read request for the next interior pixel |
| out_y | output | 6 | Output luma |
| out_u | output | 6 | Output U |
| out_v | output | 6 | Output V |
| win_active | output | 1 | High where the window is drawn |

## Verification
Blanking can fall in the same cycle as a nonzero fill code or a coloured ring. The enable and the sync guard can also both act on the same pixel. The sweep changes the frame controls at every frame start, so some frames combine blank=1 with fill codes and coloured border codes. The horizontal code changes on every line and sweeps the window across both guard limits. The bench computes each pixel's expected result on its own, giving blank priority over fill and ring, giving enable and guard priority over everything, and checking the three-cycle output timing. It compares that result and rd_req every cycle.

// File: rtl/pip_cmp_pkg.sv
package pip_cmp_pkg;

  typedef enum logic [2:0] {K_OUT, K_BORDER, K_PIC, K_FILL, K_BLACK} kind_t;

  typedef struct packed {
    logic [5:0] y;
    logic [5:0] u;
    logic [5:0] v;
  } yuv_t;

  localparam yuv_t NEUTRAL = '{y: 6'd0, u: 6'd32, v: 6'd32};
  localparam yuv_t C_GREY  = '{y: 6'd44, u: 6'd32, v: 6'd32};
  localparam yuv_t C_WHITE = '{y: 6'd63, u: 6'd32, v: 6'd32};
  localparam yuv_t C_RED   = '{y: 6'd19, u: 6'd21, v: 6'd60};
  localparam yuv_t C_GREEN = '{y: 6'd37, u: 6'd13, v: 6'd9};
  localparam yuv_t C_BLUE  = '{y: 6'd7,  u: 6'd60, v: 6'd27};

  function automatic yuv_t ring_colour(input logic [2:0] code);
    case (code)
      3'b001:  return C_GREY;
      3'b100:  return C_BLUE;
      3'b101:  return C_GREEN;
      3'b110:  return C_RED;
      3'b111:  return C_WHITE;
      default: return NEUTRAL;
    endcase
  endfunction

  function automatic yuv_t solid_colour(input logic [1:0] code);
    case (code)
      2'b01:   return C_RED;
      2'b10:   return C_GREEN;
      2'b11:   return C_BLUE;
      default: return NEUTRAL;
    endcase
  endfunction

endpackage

// File: rtl/pip_raster_count.sv
module pip_raster_count #(
  parameter int LINE_PIX    = 720,
  parameter int FRAME_LINES = 240,
  localparam int HW = $clog2(LINE_PIX),
  localparam int VW = $clog2(FRAME_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_strobe,
  input  logic          frame_strobe,
  output logic [HW-1:0] hpos,
  output logic [VW-1:0] vpos
);

  localparam logic [HW-1:0] H_LAST = HW'(LINE_PIX - 1);
  localparam logic [VW-1:0] V_LAST = VW'(FRAME_LINES - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      hpos <= '0;
      vpos <= '0;
    end else if (line_strobe) begin
      hpos <= '0;
      if (frame_strobe)        vpos <= '0;
      else if (vpos != V_LAST) vpos <= vpos + 1'b1;
    end else if (hpos != H_LAST) begin
      hpos <= hpos + 1'b1;
    end
  end

  // R2: a line strobe restarts the column count
  assert_line_restart_R2: assert property (@(posedge clk) disable iff (rst)
    line_strobe |=> (hpos == '0));

  // R2: a frame strobe with a line strobe restarts the line count
  assert_frame_restart_R2: assert property (@(posedge clk) disable iff (rst)
    (line_strobe && frame_strobe) |=> (vpos == '0));

endmodule

// File: rtl/pip_window_geom.sv
module pip_window_geom
  import pip_cmp_pkg::*;
#(
  parameter int LINE_PIX    = 720,
  parameter int FRAME_LINES = 240,
  parameter int SYNC_PIX    = 64,
  parameter int SYNC_LINES  = 20,
  parameter int LARGE_W     = 114,
  parameter int LARGE_H     = 71,
  parameter int SMALL_W     = 84,
  parameter int SMALL_H     = 54,
  parameter int BORDER_W    = 6,
  parameter int BORDER_H    = 2,
  localparam int HW = $clog2(LINE_PIX),
  localparam int VW = $clog2(FRAME_LINES)
) (
  input  logic [HW-1:0] hpos,
  input  logic [VW-1:0] vpos,
  input  logic [5:0]    x_code,
  input  logic [5:0]    y_code,
  input  logic          size_large,
  input  logic          pip_enable,
  input  logic          pip_blank,
  input  logic [1:0]    fill_code,
  input  logic [2:0]    border_code,
  output kind_t         kind,
  output yuv_t          colour
);

  localparam logic [31:0] OW_L = 32'(LARGE_W + 2 * BORDER_W);
  localparam logic [31:0] OW_S = 32'(SMALL_W + 2 * BORDER_W);
  localparam logic [31:0] OH_L = 32'(LARGE_H + 2 * BORDER_H);
  localparam logic [31:0] OH_S = 32'(SMALL_H + 2 * BORDER_H);
  localparam logic [31:0] BWX  = 32'(BORDER_W);
  localparam logic [31:0] BHX  = 32'(BORDER_H);

  logic [31:0] x0, y0, ow, oh, h, v;
  logic        fits, in_box, in_core, see_through;

  always_comb begin
    h  = 32'(hpos);
    v  = 32'(vpos);
    x0 = (32'(x_code) * 32'(LINE_PIX)) >> 6;
    y0 = (32'(y_code) * 32'(FRAME_LINES)) >> 6;
    ow = size_large ? OW_L : OW_S;
    oh = size_large ? OH_L : OH_S;
    fits = (x0 >= 32'(SYNC_PIX)) && (x0 + ow <= 32'(LINE_PIX)) &&
           (y0 >= 32'(SYNC_LINES)) && (y0 + oh <= 32'(FRAME_LINES));
    in_box  = (h >= x0) && (h < x0 + ow) && (v >= y0) && (v < y0 + oh);
    in_core = (h >= x0 + BWX) && (h < x0 + ow - BWX) &&
              (v >= y0 + BHX) && (v < y0 + oh - BHX);
    see_through = (border_code[2:1] == 2'b01);

    kind   = K_OUT;
    colour = NEUTRAL;
    if (pip_enable && fits && in_box) begin
      if (pip_blank) begin
        kind = K_BLACK;
      end else if (!in_core) begin
        if (!see_through) begin
          kind   = K_BORDER;
          colour = ring_colour(border_code);
        end
      end else if (fill_code != 2'b00) begin
        kind   = K_FILL;
        colour = solid_colour(fill_code);
      end else begin
        kind = K_PIC;
      end
    end
  end

endmodule

// File: rtl/pip_out_pipe.sv
module pip_out_pipe
  import pip_cmp_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  kind_t      kind,
  input  yuv_t       colour,
  input  logic [5:0] pix_y,
  input  logic [5:0] pix_u,
  input  logic [5:0] pix_v,
  output logic       rd_req,
  output logic [5:0] out_y,
  output logic [5:0] out_u,
  output logic [5:0] out_v,
  output logic       win_active
);

  kind_t k1, k2;
  yuv_t  c1, c2;

  always_ff @(posedge clk) begin
    if (rst) begin
      k1 <= K_OUT;
      k2 <= K_OUT;
      c1 <= NEUTRAL;
      c2 <= NEUTRAL;
      rd_req <= 1'b0;
      {out_y, out_u, out_v} <= NEUTRAL;
      win_active <= 1'b0;
    end else begin
      k1 <= kind;
      c1 <= colour;
      rd_req <= (kind == K_PIC);
      k2 <= k1;
      c2 <= c1;
      case (k2)
        K_OUT: begin
          {out_y, out_u, out_v} <= NEUTRAL;
          win_active <= 1'b0;
        end
        K_PIC: begin
          {out_y, out_u, out_v} <= {pix_y, pix_u, pix_v};
          win_active <= 1'b1;
        end
        default: begin
          {out_y, out_u, out_v} <= c2;
          win_active <= 1'b1;
        end
      endcase
    end
  end

  // R5: an undrawn pixel carries the neutral level
  assert_outside_neutral_R5: assert property (@(posedge clk) disable iff (rst)
    !win_active |-> (out_y == 6'd0 && out_u == 6'd32 && out_v == 6'd32));

  // R10: a request is followed two cycles later by the sampled memory data
  assert_read_ahead_R10: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ##2 (win_active && out_y == $past(pix_y) &&
                    out_u == $past(pix_u) && out_v == $past(pix_v)));

endmodule

// File: rtl/pip_window_compositor.sv
module pip_window_compositor
  import pip_cmp_pkg::*;
#(
  parameter int LINE_PIX    = 720,
  parameter int FRAME_LINES = 240,
  parameter int SYNC_PIX    = 64,
  parameter int SYNC_LINES  = 20,
  parameter int LARGE_W     = 114,
  parameter int LARGE_H     = 71,
  parameter int SMALL_W     = 84,
  parameter int SMALL_H     = 54,
  parameter int BORDER_W    = 6,
  parameter int BORDER_H    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       line_strobe,
  input  logic       frame_strobe,
  input  logic [5:0] x_code,
  input  logic [5:0] y_code,
  input  logic       size_large,
  input  logic       pip_enable,
  input  logic       pip_blank,
  input  logic [1:0] fill_code,
  input  logic [2:0] border_code,
  input  logic [5:0] pix_y,
  input  logic [5:0] pix_u,
  input  logic [5:0] pix_v,
  output logic       rd_req,
  output logic [5:0] out_y,
  output logic [5:0] out_u,
  output logic [5:0] out_v,
  output logic       win_active
);

  localparam int HW = $clog2(LINE_PIX);
  localparam int VW = $clog2(FRAME_LINES);

  logic [HW-1:0] hpos;
  logic [VW-1:0] vpos;
  kind_t         kind;
  yuv_t          colour;

  pip_raster_count #(.LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)) u_count (
    .clk(clk), .rst(rst), .line_strobe(line_strobe), .frame_strobe(frame_strobe),
    .hpos(hpos), .vpos(vpos)
  );

  pip_window_geom #(
    .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES), .SYNC_PIX(SYNC_PIX),
    .SYNC_LINES(SYNC_LINES), .LARGE_W(LARGE_W), .LARGE_H(LARGE_H),
    .SMALL_W(SMALL_W), .SMALL_H(SMALL_H), .BORDER_W(BORDER_W), .BORDER_H(BORDER_H)
  ) u_geom (
    .hpos(hpos), .vpos(vpos), .x_code(x_code), .y_code(y_code),
    .size_large(size_large), .pip_enable(pip_enable), .pip_blank(pip_blank),
    .fill_code(fill_code), .border_code(border_code), .kind(kind), .colour(colour)
  );

  pip_out_pipe u_pipe (
    .clk(clk), .rst(rst), .kind(kind), .colour(colour),
    .pix_y(pix_y), .pix_u(pix_u), .pix_v(pix_v), .rd_req(rd_req),
    .out_y(out_y), .out_u(out_u), .out_v(out_v), .win_active(win_active)
  );

  // R8: no request is raised unless the window was enabled
  assert_enable_gate_R8: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> $past(pip_enable));

  // R9: a fill code or blanking suppresses the memory read
  assert_fill_no_read_R9: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> ($past(fill_code) == 2'b00 && !$past(pip_blank)));

  // R7: a blanked window is drawn black
  assert_blank_black_R7: assert property (@(posedge clk) disable iff (rst)
    (win_active && $past(pip_blank, 3)) |->
      (out_y == 6'd0 && out_u == 6'd32 && out_v == 6'd32));

endmodule

// File: tb/tb_pip_window_compositor.sv
`timescale 1ns/1ps
module tb_pip_window_compositor;

  localparam int LINE_PIX = 64, FRAME_LINES = 32, SYNC_PIX = 4, SYNC_LINES = 2;
  localparam int LW = 12, LH = 7, SW = 8, SH = 5, BW = 2, BH = 1;
  localparam int NFRAMES = 60;

  logic clk = 0, rst = 1, line_strobe = 0, frame_strobe = 0;
  logic [5:0] x_code = 0, y_code = 0;
  logic size_large = 0, pip_enable = 0, pip_blank = 0;
  logic [1:0] fill_code = 0;
  logic [2:0] border_code = 0;
  logic [5:0] pix_y = 0, pix_u = 0, pix_v = 0;
  logic rd_req, win_active;
  logic [5:0] out_y, out_u, out_v;

  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  pip_window_compositor #(
    .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES), .SYNC_PIX(SYNC_PIX),
    .SYNC_LINES(SYNC_LINES), .LARGE_W(LW), .LARGE_H(LH), .SMALL_W(SW),
    .SMALL_H(SH), .BORDER_W(BW), .BORDER_H(BH)
  ) dut (.*);

  function automatic logic [17:0] ring_val(input logic [2:0] c);
    case (c)
      3'b001: return {6'd44, 6'd32, 6'd32};
      3'b100: return {6'd7, 6'd60, 6'd27};
      3'b101: return {6'd37, 6'd13, 6'd9};
      3'b110: return {6'd19, 6'd21, 6'd60};
      3'b111: return {6'd63, 6'd32, 6'd32};
      default: return {6'd0, 6'd32, 6'd32};
    endcase
  endfunction

  function automatic logic [17:0] fill_val(input logic [1:0] c);
    case (c)
      2'b01: return {6'd19, 6'd21, 6'd60};
      2'b10: return {6'd37, 6'd13, 6'd9};
      default: return {6'd7, 6'd60, 6'd27};
    endcase
  endfunction

  // kinds: 0 undrawn, 1 ring, 2 picture, 3 fill, 4 black
  task automatic classify(input int h, input int v, output int kind,
                          output logic [17:0] col, output string tag);
    int x0, y0, ow, oh;
    x0 = int'(x_code) * LINE_PIX / 64;
    y0 = int'(y_code) * FRAME_LINES / 64;
    ow = (size_large ? LW : SW) + 2 * BW;
    oh = (size_large ? LH : SH) + 2 * BH;
    kind = 0;
    col = {6'd0, 6'd32, 6'd32};
    if (!pip_enable) begin tag = "R8"; return; end
    if (x0 < SYNC_PIX || x0 + ow > LINE_PIX || y0 < SYNC_LINES || y0 + oh > FRAME_LINES) begin
      tag = "R6"; return;
    end
    if (!(h >= x0 && h < x0 + ow && v >= y0 && v < y0 + oh)) begin tag = "R2,R5"; return; end
    if (pip_blank) begin kind = 4; tag = "R7"; return; end
    if (!(h >= x0 + BW && h < x0 + ow - BW && v >= y0 + BH && v < y0 + oh - BH)) begin
      if (border_code[2:1] == 2'b01) begin tag = "R4"; return; end
      kind = 1; col = ring_val(border_code); tag = "R3"; return;
    end
    if (fill_code != 2'b00) begin kind = 3; col = fill_val(fill_code); tag = "R9"; return; end
    kind = 2; tag = "R10";
  endtask

  task automatic set_frame(input int f);
    y_code      = 6'((f * 11 + 3) % 64);
    size_large  = f[0];
    border_code = 3'((f >> 1) & 7);
    fill_code   = (f % 3 == 0) ? 2'((f >> 2) & 3) : 2'b00;
    pip_blank   = (f % 7 == 5);
    pip_enable  = (f % 11 != 4);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    int mh, mv, f, cyc;
    int ek [3];
    logic [17:0] ec [3];
    string et [3];
    int k;
    logic [17:0] c, got, expv;
    string t;
    logic exp_act, exp_rd;
    mh = 0; mv = 0; f = 0; cyc = 0;
    for (int i = 0; i < 3; i++) begin ek[i] = 0; ec[i] = {6'd0, 6'd32, 6'd32}; et[i] = "R1"; end

    repeat (3) @(negedge clk);
    checks++;
    if (!(out_y == 0 && out_u == 32 && out_v == 32 && !win_active && !rd_req)) begin
      failures++;
      $display("FAIL R1 reset outputs y=%0d u=%0d v=%0d act=%0b rd=%0b expected 0 32 32 0 0",
               out_y, out_u, out_v, win_active, rd_req);
    end
    set_frame(0);
    x_code = 6'd0;
    rst = 0;

    while (f < NFRAMES) begin
      @(negedge clk);
      cyc++;
      // model counters for the edge just passed
      if (rst) begin mh = 0; mv = 0; end
      else if (line_strobe) begin
        mh = 0;
        if (frame_strobe) mv = 0; else if (mv < FRAME_LINES - 1) mv++;
      end else if (mh < LINE_PIX - 1) mh++;

      // outputs reflect the class recorded three pushes ago
      expv = (ek[2] == 2) ? {pix_y, pix_u, pix_v} : ec[2];
      exp_act = (ek[2] != 0);
      got = {out_y, out_u, out_v};
      checks++;
      if (got !== expv || win_active !== exp_act) begin
        failures++;
        $display("FAIL %s pixel cyc=%0d got y=%0d u=%0d v=%0d act=%0b expected y=%0d u=%0d v=%0d act=%0b",
                 et[2], cyc, out_y, out_u, out_v, win_active,
                 expv[17:12], expv[11:6], expv[5:0], exp_act);
      end
      exp_rd = (ek[0] == 2);
      checks++;
      if (rd_req !== exp_rd) begin
        failures++;
        $display("FAIL R10 rd_req cyc=%0d got %0b expected %0b (%s)", cyc, rd_req, exp_rd, et[0]);
      end

      // drive next inputs
      line_strobe = (mh == LINE_PIX - 1);
      frame_strobe = line_strobe && (mv == FRAME_LINES - 1);
      if (frame_strobe) begin f++; set_frame(f); end
      if (line_strobe) x_code = 6'(((frame_strobe ? 0 : mv + 1) * 9 + f * 5) % 64);
      pix_y = 6'(cyc);
      pix_u = 6'(cyc * 3);
      pix_v = 6'(cyc * 5 + 7);

      // record the class of the current counter position
      classify(mh, mv, k, c, t);
      ek[2] = ek[1]; ec[2] = ec[1]; et[2] = et[1];
      ek[1] = ek[0]; ec[1] = ec[0]; et[1] = et[0];
      ek[0] = k; ec[0] = c; et[0] = t;
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule